// File: doc/BRIEF.md
# Open-Page SDRAM Row Tracker

This block sits between a host that issues single read and write requests and the command pins of an SDRAM device. Each request names a bank, a row, a column and a direction. The block keeps a record, per bank, of which row is currently open. From that record it emits the shortest legal command sequence for the request:

- a lone column command when the row is already open;
- an activate followed by the column command when the bank is idle;
- a precharge, then an activate, then the column command when a different row is open in that bank.

Commands leave the block one per clock. Every unused cycle carries a NOP. The spacing from precharge to activate and from activate to column command is set by parameters. With every read, the block also reports how many cycles will pass from request acceptance until the read data arrives, so a capture pipeline can line up with the data.

Refreshes are requested on a separate level input. A refresh takes precedence over host traffic whenever a sequence has just finished. If any row is open, the block first closes all banks with a precharge-all, then issues the refresh. Afterwards every bank counts as closed, so the next access to any bank starts with an activation.

Top module: `sdram_page_tracker`

## Requirements
- R1: Reset, or a later return to reset, marks every bank closed. While in reset and after it, the command bus carries NOP (cmd_valid low, code 0) until a request or refresh arrives, and req_ready is high.
- R2: A request whose bank has the same row open is served by its column command alone, issued in the cycle after acceptance.
- R3: A request to a bank with no open row issues ACTIVATE (bank, row on cmd_addr) in the cycle after acceptance, then the column command T_RCD cycles later.
- R4: A request to a bank holding a different open row issues PRECHARGE for that bank (cmd_addr bit AP_BIT low) in the cycle after acceptance. ACTIVATE follows T_RP cycles later, and the column command T_RCD cycles after that.
- R5: Open rows are remembered for all banks at once. After accesses to another bank, returning to a bank with the same row still gives a hit with no activation.
- R6: Every cycle between issued commands carries NOP with cmd_valid low.
- R7: A request is accepted only while no sequence is running. req_ready is low from the cycle after acceptance through the column command cycle, and high again in the following cycle.
- R8: rd_lat_valid is high exactly in READ command cycles. rd_lat then equals the column command's offset from the acceptance cycle plus T_CL, i.e. 1+T_CL, 1+T_RCD+T_CL or 1+T_RP+T_RCD+T_CL.
- R9: When ref_req is high in an idle cycle, req_ready is low and the refresh sequence starts instead of any pending request. The request is accepted once the refresh is done and ref_req is dropped.
- R10: A refresh with any bank open issues PRECHARGE with cmd_addr bit AP_BIT high in the first cycle, then REFRESH T_RP cycles later. Every bank is closed afterwards.
- R11: A refresh with no bank open issues REFRESH in the first cycle.
- R12: Command codes are NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4, REFRESH=5. Column commands carry the column zero-extended on cmd_addr and the request bank on cmd_bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Request bank |
| req_row | input | 13 | Request row |
| req_col | input | 10 | Request column |
| ref_req | input | 1 | Refresh wanted; held until REFRESH appears on the command bus |
| cmd_valid | output | 1 | A command other than NOP is on the bus |
| cmd_code | output | 3 | Encoded command (see R12) |
| cmd_bank | output | 2 | Command bank |
| cmd_addr | output | 13 | Row, column or precharge-all flag |
| rd_lat_valid | output | 1 | rd_lat is meaningful (READ cycle) |
| rd_lat | output | 4 | Cycles from acceptance to read data |

## Verification
The hardest state to reach is a refresh request that collides with a pending host request while a row is open. In that state the refresh has to win, close every bank and then leave the held request to be treated as a fresh activation. The stimulus first opens rows through a vector sequence, then raises ref_req and req_valid in the same idle cycle, and checks that req_ready stays low and that the next command is a precharge-all. It then checks that the delayed request produces an activation rather than a hit. A bank switch that returns to a still-open row, and a reset applied while rows are open, are also driven deliberately so that a hit is expected in one case and an activation in the other.

// File: rtl/spt_pkg.sv
package spt_pkg;
   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4,
      CMD_REF = 3'd5
   } spt_cmd_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_PRE,
      S_ACT,
      S_COL,
      S_PALL,
      S_REF
   } spt_state_e;
endpackage

// File: rtl/spt_bank_table.sv
module spt_bank_table #(
   parameter int BANKS = 4,
   parameter int ROW_W = 13,
   localparam int BANK_W = $clog2(BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] look_bank,
   input  logic [ROW_W-1:0]  look_row,
   output logic              look_open,
   output logic              look_match,
   output logic              any_open,
   input  logic              act_en,
   input  logic [BANK_W-1:0] act_bank,
   input  logic [ROW_W-1:0]  act_row,
   input  logic              pre_en,
   input  logic [BANK_W-1:0] pre_bank,
   input  logic              pre_all
);
   logic [BANKS-1:0] open_vec;
   logic [ROW_W-1:0] row_arr [BANKS];

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic             open_r;
      logic [ROW_W-1:0] row_r;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            open_r <= 1'b0;
            row_r  <= '0;
         end else if (pre_all || (pre_en && pre_bank == BANK_W'(b))) begin
            open_r <= 1'b0;
         end else if (act_en && act_bank == BANK_W'(b)) begin
            open_r <= 1'b1;
            row_r  <= act_row;
         end
      end
      assign open_vec[b] = open_r;
      assign row_arr[b]  = row_r;
   end

   assign look_open  = open_vec[look_bank];
   assign look_match = (row_arr[look_bank] == look_row);
   assign any_open   = |open_vec;

   // R3
   act_to_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_en |-> !open_vec[act_bank]);

   // R4
   pre_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pre_en |-> open_vec[pre_bank]);
endmodule

// File: rtl/spt_cmd_seq.sv
module spt_cmd_seq
   import spt_pkg::*;
#(
   parameter int BANKS  = 4,
   parameter int ROW_W  = 13,
   parameter int COL_W  = 10,
   parameter int T_RP   = 3,
   parameter int T_RCD  = 2,
   parameter int T_CL   = 3,
   parameter int AP_BIT = 10,
   localparam int BANK_W  = $clog2(BANKS),
   localparam int LAT_MAX = 1 + T_RP + T_RCD + T_CL,
   localparam int LAT_W   = $clog2(LAT_MAX + 1),
   localparam int GAP_MAX = (T_RP > T_RCD) ? T_RP : T_RCD,
   localparam int CNT_W   = $clog2(GAP_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic              ref_req,
   input  logic              look_open,
   input  logic              look_match,
   input  logic              any_open,
   output logic              act_en,
   output logic [BANK_W-1:0] act_bank,
   output logic [ROW_W-1:0]  act_row,
   output logic              pre_en,
   output logic [BANK_W-1:0] pre_bank,
   output logic              pre_all,
   output logic              cmd_valid,
   output spt_cmd_e          cmd_code,
   output logic [BANK_W-1:0] cmd_bank,
   output logic [ROW_W-1:0]  cmd_addr,
   output logic              rd_lat_valid,
   output logic [LAT_W-1:0]  rd_lat
);
   spt_state_e        state_q, state_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic [LAT_W-1:0]  lat_q, lat_d;
   logic              wr_q;
   logic [BANK_W-1:0] bank_q;
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q;
   logic              accept;
   logic              gap_wait;

   assign req_ready = (state_q == S_IDLE) && !ref_req;
   assign accept    = req_ready && req_valid;
   assign gap_wait  = (cnt_q != '0);

   always_comb begin
      state_d      = state_q;
      cnt_d        = cnt_q;
      lat_d        = lat_q;
      cmd_code     = CMD_NOP;
      cmd_bank     = '0;
      cmd_addr     = '0;
      act_en       = 1'b0;
      pre_en       = 1'b0;
      pre_all      = 1'b0;
      rd_lat_valid = 1'b0;
      unique case (state_q)
         S_IDLE: begin
            if (ref_req) begin
               cnt_d   = '0;
               state_d = any_open ? S_PALL : S_REF;
            end else if (req_valid) begin
               cnt_d = '0;
               if (look_open && look_match) begin
                  state_d = S_COL;
                  lat_d   = LAT_W'(1 + T_CL);
               end else if (look_open) begin
                  state_d = S_PRE;
                  lat_d   = LAT_W'(1 + T_RP + T_RCD + T_CL);
               end else begin
                  state_d = S_ACT;
                  lat_d   = LAT_W'(1 + T_RCD + T_CL);
               end
            end
         end
         S_PRE: begin
            cmd_code = CMD_PRE;
            cmd_bank = bank_q;
            pre_en   = 1'b1;
            cnt_d    = CNT_W'(T_RP - 1);
            state_d  = S_ACT;
         end
         S_ACT: begin
            if (gap_wait) begin
               cnt_d = cnt_q - 1'b1;
            end else begin
               cmd_code = CMD_ACT;
               cmd_bank = bank_q;
               cmd_addr = row_q;
               act_en   = 1'b1;
               cnt_d    = CNT_W'(T_RCD - 1);
               state_d  = S_COL;
            end
         end
         S_COL: begin
            if (gap_wait) begin
               cnt_d = cnt_q - 1'b1;
            end else begin
               cmd_code              = wr_q ? CMD_WR : CMD_RD;
               cmd_bank              = bank_q;
               cmd_addr[COL_W-1:0]   = col_q;
               rd_lat_valid          = !wr_q;
               state_d               = S_IDLE;
            end
         end
         S_PALL: begin
            cmd_code         = CMD_PRE;
            cmd_addr[AP_BIT] = 1'b1;
            pre_all          = 1'b1;
            cnt_d            = CNT_W'(T_RP - 1);
            state_d          = S_REF;
         end
         S_REF: begin
            if (gap_wait) begin
               cnt_d = cnt_q - 1'b1;
            end else begin
               cmd_code = CMD_REF;
               pre_all  = 1'b1;
               state_d  = S_IDLE;
            end
         end
         default: state_d = S_IDLE;
      endcase
   end

   assign cmd_valid = (cmd_code != CMD_NOP);
   assign act_bank  = bank_q;
   assign act_row   = row_q;
   assign pre_bank  = bank_q;
   assign rd_lat    = lat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         cnt_q   <= '0;
         lat_q   <= '0;
         wr_q    <= 1'b0;
         bank_q  <= '0;
         row_q   <= '0;
         col_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         lat_q   <= lat_d;
         if (accept) begin
            wr_q   <= req_write;
            bank_q <= req_bank;
            row_q  <= req_row;
            col_q  <= req_col;
         end
      end
   end

   // Checker counters: cycles since acceptance, since last precharge, since last activate
   logic [LAT_W-1:0] el_q;
   logic [CNT_W-1:0] pre_gap_q, act_gap_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         el_q      <= '0;
         pre_gap_q <= CNT_W'(T_RP);
         act_gap_q <= CNT_W'(T_RCD);
      end else begin
         if (accept)
            el_q <= LAT_W'(1);
         else if (state_q != S_IDLE && el_q != '1)
            el_q <= el_q + 1'b1;
         if (cmd_code == CMD_PRE)
            pre_gap_q <= CNT_W'(1);
         else if (pre_gap_q < CNT_W'(T_RP))
            pre_gap_q <= pre_gap_q + 1'b1;
         if (cmd_code == CMD_ACT)
            act_gap_q <= CNT_W'(1);
         else if (act_gap_q < CNT_W'(T_RCD))
            act_gap_q <= act_gap_q + 1'b1;
      end
   end

   // R8
   rd_lat_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_code == CMD_RD) |-> (rd_lat == el_q + LAT_W'(T_CL)));

   // R4
   rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_code == CMD_ACT || cmd_code == CMD_REF) |-> (pre_gap_q >= CNT_W'(T_RP)));

   // R3
   rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_code == CMD_RD || cmd_code == CMD_WR) |-> (act_gap_q >= CNT_W'(T_RCD)));

   // R9
   ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE && ref_req) |=>
         ((cmd_code == CMD_PRE && cmd_addr[AP_BIT]) || cmd_code == CMD_REF));

   // R10
   ref_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_code == CMD_REF) |-> !any_open);
endmodule

// File: rtl/sdram_page_tracker.sv
module sdram_page_tracker
   import spt_pkg::*;
#(
   parameter int BANKS  = 4,
   parameter int ROW_W  = 13,
   parameter int COL_W  = 10,
   parameter int T_RP   = 3,
   parameter int T_RCD  = 2,
   parameter int T_CL   = 3,
   parameter int AP_BIT = 10,
   localparam int BANK_W  = $clog2(BANKS),
   localparam int LAT_MAX = 1 + T_RP + T_RCD + T_CL,
   localparam int LAT_W   = $clog2(LAT_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic              ref_req,
   output logic              cmd_valid,
   output logic [2:0]        cmd_code,
   output logic [BANK_W-1:0] cmd_bank,
   output logic [ROW_W-1:0]  cmd_addr,
   output logic              rd_lat_valid,
   output logic [LAT_W-1:0]  rd_lat
);
   if (BANKS < 2 || (BANKS & (BANKS - 1)) != 0) begin : g_bad_banks
      $error("BANKS must be a power of two, at least 2");
   end
   if (T_RP < 1 || T_RCD < 1 || T_CL < 1) begin : g_bad_timing
      $error("T_RP, T_RCD and T_CL must each be at least 1");
   end
   if (AP_BIT >= ROW_W || COL_W > AP_BIT) begin : g_bad_addr
      $error("AP_BIT must lie above the column field and inside the row field");
   end

   logic              look_open, look_match, any_open;
   logic              act_en, pre_en, pre_all;
   logic [BANK_W-1:0] act_bank, pre_bank;
   logic [ROW_W-1:0]  act_row;
   spt_cmd_e          cmd_e;

   spt_bank_table #(
      .BANKS (BANKS),
      .ROW_W (ROW_W)
   ) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .look_bank  (req_bank),
      .look_row   (req_row),
      .look_open  (look_open),
      .look_match (look_match),
      .any_open   (any_open),
      .act_en     (act_en),
      .act_bank   (act_bank),
      .act_row    (act_row),
      .pre_en     (pre_en),
      .pre_bank   (pre_bank),
      .pre_all    (pre_all)
   );

   spt_cmd_seq #(
      .BANKS  (BANKS),
      .ROW_W  (ROW_W),
      .COL_W  (COL_W),
      .T_RP   (T_RP),
      .T_RCD  (T_RCD),
      .T_CL   (T_CL),
      .AP_BIT (AP_BIT)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_write    (req_write),
      .req_bank     (req_bank),
      .req_row      (req_row),
      .req_col      (req_col),
      .ref_req      (ref_req),
      .look_open    (look_open),
      .look_match   (look_match),
      .any_open     (any_open),
      .act_en       (act_en),
      .act_bank     (act_bank),
      .act_row      (act_row),
      .pre_en       (pre_en),
      .pre_bank     (pre_bank),
      .pre_all      (pre_all),
      .cmd_valid    (cmd_valid),
      .cmd_code     (cmd_e),
      .cmd_bank     (cmd_bank),
      .cmd_addr     (cmd_addr),
      .rd_lat_valid (rd_lat_valid),
      .rd_lat       (rd_lat)
   );

   assign cmd_code = cmd_e;
endmodule

// File: tb/sdram_page_tracker_tb.sv
module sdram_page_tracker_tb;
   localparam int BANKS = 4, ROW_W = 13, COL_W = 10;
   localparam int T_RP = 3, T_RCD = 2, T_CL = 3, AP_BIT = 10;
   localparam int BANK_W = $clog2(BANKS);
   localparam int LAT_W = $clog2(1 + T_RP + T_RCD + T_CL + 1);

   // kinds: 0 hit, 1 idle bank, 2 row conflict, 3 refresh with open rows, 4 refresh with none open
   localparam int NVEC = 16;
   localparam logic [28:0] VEC [NVEC] = '{
      {3'd1, 1'b0, 2'd0, 13'd5,     10'd7},
      {3'd0, 1'b0, 2'd0, 13'd5,     10'd8},
      {3'd1, 1'b1, 2'd1, 13'd9,     10'd1},
      {3'd0, 1'b0, 2'd0, 13'd5,     10'd2},
      {3'd0, 1'b1, 2'd1, 13'd9,     10'd3},
      {3'd2, 1'b0, 2'd1, 13'd12,    10'd4},
      {3'd1, 1'b1, 2'd2, 13'h1FFF,  10'h3FF},
      {3'd1, 1'b0, 2'd3, 13'd1,     10'd0},
      {3'd0, 1'b0, 2'd2, 13'h1FFF,  10'd5},
      {3'd3, 1'b0, 2'd0, 13'd0,     10'd0},
      {3'd1, 1'b0, 2'd1, 13'd12,    10'd6},
      {3'd0, 1'b1, 2'd1, 13'd12,    10'd9},
      {3'd2, 1'b0, 2'd1, 13'd3,     10'd9},
      {3'd3, 1'b0, 2'd0, 13'd0,     10'd0},
      {3'd4, 1'b0, 2'd0, 13'd0,     10'd0},
      {3'd1, 1'b1, 2'd3, 13'd1,     10'd1}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_write = 1'b0;
   logic [BANK_W-1:0] req_bank = '0;
   logic [ROW_W-1:0]  req_row = '0;
   logic [COL_W-1:0]  req_col = '0;
   logic              ref_req = 1'b0;
   logic              cmd_valid;
   logic [2:0]        cmd_code;
   logic [BANK_W-1:0] cmd_bank;
   logic [ROW_W-1:0]  cmd_addr;
   logic              rd_lat_valid;
   logic [LAT_W-1:0]  rd_lat;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   sdram_page_tracker #(
      .BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W),
      .T_RP(T_RP), .T_RCD(T_RCD), .T_CL(T_CL), .AP_BIT(AP_BIT)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .ref_req(ref_req),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
      .cmd_addr(cmd_addr), .rd_lat_valid(rd_lat_valid), .rd_lat(rd_lat)
   );

   always #10 clk = ~clk;

   task automatic chk_eq(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic idle_bus(string tag);
      chk_eq(tag, "cmd_valid idle", int'(cmd_valid), 0);
      chk_eq(tag, "cmd_code idle", int'(cmd_code), 0);
      chk_eq(tag, "rd_lat_valid idle", int'(rd_lat_valid), 0);
   endtask

   task automatic run_access(bit wr, int bank, int row, int col, int kind, string tag);
      int col_off;
      @(negedge clk);
      chk_eq("R7", "req_ready before request", int'(req_ready), 1);
      req_valid = 1'b1; req_write = wr;
      req_bank = BANK_W'(bank); req_row = ROW_W'(row); req_col = COL_W'(col);
      @(negedge clk);
      req_valid = 1'b0;
      col_off = (kind == 0) ? 1 : (kind == 1) ? 1 + T_RCD : 1 + T_RP + T_RCD;
      for (int k = 1; k <= col_off; k++) begin
         int exp;
         if (k > 1) @(negedge clk);
         if (k == col_off)                    exp = wr ? 3 : 2;
         else if (kind == 2 && k == 1)        exp = 4;
         else if (kind == 2 && k == 1 + T_RP) exp = 1;
         else if (kind == 1 && k == 1)        exp = 1;
         else                                 exp = 0;
         chk_eq(tag, "cmd_code", int'(cmd_code), exp);
         chk_eq("R6", "cmd_valid vs NOP", int'(cmd_valid), int'(exp != 0));
         chk_eq("R7", "req_ready during sequence", int'(req_ready), 0);
         if (exp == 1) begin
            chk_eq("R12", "ACT bank", int'(cmd_bank), bank);
            chk_eq("R12", "ACT row", int'(cmd_addr), row);
         end else if (exp == 4) begin
            chk_eq("R4", "PRE bank", int'(cmd_bank), bank);
            chk_eq("R4", "PRE single-bank flag", int'(cmd_addr[AP_BIT]), 0);
         end else if (exp == 2 || exp == 3) begin
            chk_eq("R12", "column bank", int'(cmd_bank), bank);
            chk_eq("R12", "column addr", int'(cmd_addr), col);
            chk_eq("R8", "rd_lat_valid on column", int'(rd_lat_valid), int'(!wr));
            if (!wr) chk_eq("R8", "rd_lat value", int'(rd_lat), col_off + T_CL);
         end else begin
            chk_eq("R8", "rd_lat_valid on NOP", int'(rd_lat_valid), 0);
         end
      end
   endtask

   task automatic run_refresh(int kind, string tag);
      int last;
      @(negedge clk);
      ref_req = 1'b1;
      #1;
      chk_eq("R9", "req_ready with ref_req", int'(req_ready), 0);
      @(negedge clk);
      last = (kind == 3) ? 1 + T_RP : 1;
      for (int k = 1; k <= last; k++) begin
         int exp;
         if (k > 1) @(negedge clk);
         if (k == last)     exp = 5;
         else if (k == 1)   exp = 4;
         else               exp = 0;
         chk_eq(tag, "refresh cmd_code", int'(cmd_code), exp);
         if (exp == 4) chk_eq("R10", "precharge-all flag", int'(cmd_addr[AP_BIT]), 1);
         if (exp == 0) chk_eq("R6", "cmd_valid in gap", int'(cmd_valid), 0);
         if (k == last) ref_req = 1'b0;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      idle_bus("R1");
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         idle_bus("R1");
         chk_eq("R1", "req_ready after reset", int'(req_ready), 1);
      end

      // Vector walk: R2 hit, R3 idle bank, R4 conflict, R5 bank switching, R10/R11 refresh
      for (int i = 0; i < NVEC; i++) begin
         logic [28:0] v;
         int kind;
         v = VEC[i];
         kind = int'(v[28:26]);
         case (kind)
            0: run_access(v[25], int'(v[24:23]), int'(v[22:10]), int'(v[9:0]), 0, "R2/R5");
            1: run_access(v[25], int'(v[24:23]), int'(v[22:10]), int'(v[9:0]), 1, "R3");
            2: run_access(v[25], int'(v[24:23]), int'(v[22:10]), int'(v[9:0]), 2, "R4");
            3: run_refresh(3, "R10");
            default: run_refresh(4, "R11");
         endcase
      end

      // R9: refresh and request raised together with bank 3 open; refresh wins
      @(negedge clk);
      ref_req = 1'b1;
      req_valid = 1'b1; req_write = 1'b0; req_bank = 2'd3; req_row = 13'd1; req_col = 10'd4;
      #1;
      chk_eq("R9", "req_ready blocked by refresh", int'(req_ready), 0);
      @(negedge clk);
      chk_eq("R9", "precharge-all before request", int'(cmd_code), 4);
      chk_eq("R9", "precharge-all flag", int'(cmd_addr[AP_BIT]), 1);
      repeat (T_RP) @(negedge clk);
      chk_eq("R9", "refresh issued", int'(cmd_code), 5);
      ref_req = 1'b0; req_valid = 1'b0;
      // R10: held request now finds bank 3 closed
      run_access(1'b0, 3, 1, 4, 1, "R9/R10");

      // R1: reset while rows are open closes them
      run_access(1'b1, 2, 77, 3, 1, "R3");
      run_access(1'b0, 2, 77, 5, 0, "R2");
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      idle_bus("R1");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      idle_bus("R1");
      run_access(1'b0, 2, 77, 5, 1, "R1");

      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule